// File: doc/BRIEF.md
# Pulse-Framed Synchronous Serial Master

This block is the master end of a synchronous serial link. The start of every word is marked by a pulse on the frame line that lasts one serial clock period. The block takes words from an external transmit FIFO through a pop strobe and returns received words to an external receive FIFO through a push strobe. The word length can be set from 4 to 16 bits.

The serial clock is built from the system clock with a programmable even divider. All logic runs on the system clock, and the serial clock is never used as a clock inside the block. While the link is idle, the serial clock and frame line stay low and the transmit line is released. When a word is ready, the block sends a frame-sync period followed by the data bits, MSB first. If another word is waiting when a frame ends, the next sync period starts at once, so frames can run back to back.

Top module: `pfs_serial_master`

## Requirements
- R1: While idle, `sclk`, `fss`, `txd_oe` and `busy` are all low.
- R2: A frame starts with `sclk` rising and `fss` rising in the same cycle. `fss` then stays high for exactly one serial clock period.
- R3: The serial clock period is 2*max(1, floor(`cfg_div`/2)) system clock cycles, with equal high and low halves. Odd divider values round down, and values below 2 act as 2.
- R4: `tx_pop` pulses once per frame, in the cycle the frame starts. The low L bits of `tx_word` are sent MSB first. The first bit appears on the rising edge after the sync period, and each later bit changes only on a rising edge. While the frame runs, `txd_oe` is high.
- R5: `rxd` is sampled on each falling edge of the serial clock, MSB first. The received word on `rx_word` is right-justified in the low L bits, and the bits above are zero.
- R6: The received word is committed in the cycle that holds the first rising serial edge after the LSB is sampled. That is (2L+2)·H − 1 system cycles after the cycle in which `fss` first reads high, where H is half the serial period.
- R7: If `tx_avail` is high when a frame ends, the next sync pulse starts in that same cycle, and `busy` does not drop between the frames.
- R8: The effective length L is `cfg_len` limited to the range 4 to 16. L is captured at the start of each frame.
- R9: If `rx_full` is high at commit time, no push occurs and the sticky `ovr_flag` is set. `ovr_clr` clears the flag. When a set and a clear happen in the same cycle, the set wins.
- R10: `busy` is high from the start of the first sync pulse until the commit of the last word, provided no further word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Serial clock divider (system cycles per serial period) |
| cfg_len | input | 5 | Requested word length in bits |
| tx_avail | input | 1 | Transmit FIFO holds a word |
| tx_word | input | 16 | Word at the head of the transmit FIFO |
| tx_pop | output | 1 | Removes the head word from the transmit FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_word | output | 16 | Received word, right-justified |
| rx_push | output | 1 | Writes `rx_word` into the receive FIFO |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| sclk | output | 1 | Serial clock |
| fss | output | 1 | Frame-sync pulse |
| txd_o | output | 1 | Transmit data value |
| txd_oe | output | 1 | Transmit data drive enable (low means released) |
| rxd | input | 1 | Receive data |
| busy | output | 1 | Frame activity in progress |

## Verification
The embedded assertions check, on every cycle, the relations that are local in time:
- the idle levels of the outputs;
- a pop always being followed by a raised sync line and serial clock;
- the sync pulse starting together with a rising serial clock;
- the transmit line holding steady between rising edges;
- no push while the receive FIFO is full;
- the overrun flag staying set.

Other behaviour covers whole frames and can only be shown by the bench scenarios, which act as a model serial slave:
- the bit order and content in both directions;
- the length clamping;
- the exact serial period and sync width for each divider;
- the commit cycle of each word;
- `busy` staying high across a back-to-back burst.

// File: rtl/pfs_serial_master.sv
module pfs_serial_master #(
  parameter int WORD_W  = 16,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 5,
  parameter int MIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              tx_avail,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_push,
  input  logic              ovr_clr,
  output logic              ovr_flag,
  output logic              sclk,
  output logic              fss,
  output logic              txd_o,
  output logic              txd_oe,
  input  logic              rxd,
  output logic              busy
);

  localparam logic [LEN_W-1:0] WORD_L = LEN_W'(WORD_W);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);

  typedef enum logic [1:0] {IDLE, SYNC, BITS} st_t;

  st_t               st;
  logic [DIV_W-1:0]  cnt, half;
  logic [LEN_W-1:0]  len_eff, bits_left;
  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic              edge_due, rise_evt, fall_evt, last, start;

  assign half     = (cfg_div < DIV_W'(2)) ? DIV_W'(1) : (cfg_div >> 1);
  assign len_eff  = (cfg_len < MIN_L) ? MIN_L : ((cfg_len > WORD_L) ? WORD_L : cfg_len);

  assign edge_due = (st != IDLE) && (cnt == half - DIV_W'(1));
  assign rise_evt = edge_due && !sclk;
  assign fall_evt = edge_due && sclk;
  assign last     = (st == BITS) && rise_evt && (bits_left == '0);
  assign start    = tx_avail && ((st == IDLE) || last);

  assign tx_pop   = start;
  assign rx_push  = last && !rx_full;
  assign rx_word  = rx_sh;
  assign busy     = (st != IDLE);
  assign txd_oe   = busy;
  assign txd_o    = (st == BITS) ? tx_sh[WORD_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      sclk      <= 1'b0;
      fss       <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
    end else if (start) begin
      st        <= SYNC;
      cnt       <= '0;
      sclk      <= 1'b1;
      fss       <= 1'b1;
      tx_sh     <= tx_word << (WORD_L - len_eff);
      rx_sh     <= '0;
      bits_left <= len_eff;
    end else if (last) begin
      st   <= IDLE;
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (st != IDLE) begin
      if (edge_due) begin
        cnt  <= '0;
        sclk <= ~sclk;
        if (rise_evt) begin
          fss <= 1'b0;
          if (st == SYNC) st <= BITS;
          else            tx_sh <= tx_sh << 1;
        end else if (fall_evt && st == BITS) begin
          rx_sh     <= {rx_sh[WORD_W-2:0], rxd};
          bits_left <= bits_left - LEN_W'(1);
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovr_flag <= 1'b0;
    else if (last && rx_full)  ovr_flag <= 1'b1;
    else if (ovr_clr)          ovr_flag <= 1'b0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !fss && !txd_oe));

  // R2
  sync_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fss) |-> $rose(sclk));

  // R4
  pop_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (fss && sclk && busy));

  // R4
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BITS && !rise_evt) |=> $stable(txd_o));

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

endmodule

// File: tb/tb_pfs_serial_master.sv
module tb_pfs_serial_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd4;
  logic [4:0]  cfg_len = 5'd8;
  logic        tx_avail, tx_pop, rx_full = 1'b0, rx_push, ovr_clr = 1'b0, ovr_flag;
  logic [15:0] tx_word, rx_word;
  logic        sclk, fss, txd_o, txd_oe, rxd = 1'b0, busy;

  always #5 clk = ~clk;

  pfs_serial_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .tx_avail(tx_avail), .tx_word(tx_word), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_word(rx_word), .rx_push(rx_push),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .sclk(sclk), .fss(fss),
    .txd_o(txd_o), .txd_oe(txd_oe), .rxd(rxd), .busy(busy));

  logic [15:0] tx_mem [0:63];
  logic [15:0] rx_mem [0:63];
  logic [15:0] slv_mem [0:63];
  logic [15:0] tx_cap [0:63];
  int n_tx = 0, rd_idx = 0, rx_n = 0;
  int errors = 0, checks = 0;
  int cur_len = 8, exp_per = 4, fr_count = 0, busy_falls = 0;

  assign tx_avail = rd_idx < n_tx;
  assign tx_word  = tx_mem[rd_idx[5:0]];

  always @(posedge clk) begin
    if (tx_pop) rd_idx <= rd_idx + 1;
    if (rx_push) begin rx_mem[rx_n[5:0]] <= rx_word; rx_n <= rx_n + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l < 4) ? 4 : ((l > 16) ? 16 : l);
  endfunction
  function automatic int half_of(input int d);
    return (d < 2) ? 1 : d / 2;
  endfunction
  function automatic logic [15:0] mask(input int l);
    return 16'((32'd1 << l) - 1);
  endfunction

  // model serial slave and per-edge timing checks
  initial begin
    bit p_s = 0, p_f = 0, p_b = 0, in_fr = 0;
    int cyc = 0, last_rise = 0, fss_rise = 0, fr_start = 0, cur = 0, drv = 0, got = 0;
    logic [15:0] cap = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (sclk && !p_s) begin
        if (in_fr) chk(cyc - last_rise == exp_per, "R3 period", cyc - last_rise, exp_per);
        last_rise = cyc;
        if (fss) begin
          cur = fr_count; fr_count++; drv = 0; got = 0; cap = '0;
          fr_start = cyc; in_fr = 1;
        end else if (in_fr && drv < cur_len) begin
          rxd = slv_mem[cur[5:0]][cur_len-1-drv];
          drv++;
        end
      end
      if (!sclk && p_s && !fss && in_fr && got < cur_len) begin
        cap = {cap[14:0], txd_o};
        got++;
        if (got == cur_len) tx_cap[cur[5:0]] = cap;
      end
      if (fss && !p_f) fss_rise = cyc;
      if (!fss && p_f) chk(cyc - fss_rise == exp_per, "R2 sync width", cyc - fss_rise, exp_per);
      if (rx_push) chk(cyc - fr_start == (2*cur_len+2)*(exp_per/2) - 1, "R6 commit cycle",
                       cyc - fr_start, (2*cur_len+2)*(exp_per/2) - 1);
      if (!busy && p_b) busy_falls++;
      if (!busy) in_fr = 0;
      p_s = sclk; p_f = fss; p_b = busy;
    end
  end

  task automatic burst(input int lcfg, input int div, input int n, input bit full);
    int f0, r0, t0, b0, L, guard;
    cfg_len = 5'(lcfg); cfg_div = 8'(div); rx_full = full;
    L = eff_len(lcfg); cur_len = L; exp_per = 2 * half_of(div);
    f0 = fr_count; r0 = rx_n; t0 = n_tx; b0 = busy_falls;
    for (int i = 0; i < n; i++) begin
      slv_mem[(f0+i) % 64] = 16'($urandom);
      tx_mem[(t0+i) % 64]  = 16'($urandom);
    end
    @(negedge clk);
    n_tx = t0 + n;
    guard = 0;
    while ((rd_idx < n_tx || busy) && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(tx_cap[(f0+i)%64] == (tx_mem[(t0+i)%64] & mask(L)), "R4 tx bits",
          tx_cap[(f0+i)%64], tx_mem[(t0+i)%64] & mask(L));
      if (!full)
        chk(rx_mem[(r0+i)%64] == (slv_mem[(f0+i)%64] & mask(L)), "R5 rx word",
            rx_mem[(r0+i)%64], slv_mem[(f0+i)%64] & mask(L));
    end
    if (full) begin
      chk(rx_n == r0, "R9 no push when full", rx_n, r0);
      chk(ovr_flag == 1'b1, "R9 overrun set", ovr_flag, 1);
    end
    chk(busy_falls - b0 == 1, "R7 R10 one busy span", busy_falls - b0, 1);
    chk({sclk, fss, txd_oe, busy} == 4'b0, "R1 idle outputs", {sclk, fss, txd_oe, busy}, 0);
    rx_full = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10 watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk({sclk, fss, txd_oe, busy, ovr_flag} == 5'b0, "R1 reset state",
        {sclk, fss, txd_oe, busy, ovr_flag}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    burst(8, 4, 3, 0);
    burst(4, 2, 2, 0);
    burst(16, 6, 2, 0);
    burst(2, 1, 2, 0);    // R8 clamp low, R3 divider floor
    burst(25, 7, 2, 0);   // R8 clamp high, R3 odd divider
    for (int k = 0; k < 5; k++)
      burst(4 + int'($urandom % 13), int'($urandom % 10), 1 + int'($urandom % 3), 0);
    burst(10, 4, 1, 1);   // R9 overrun
    repeat (5) @(negedge clk);
    chk(ovr_flag == 1'b1, "R9 flag sticky", ovr_flag, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R9 flag cleared", ovr_flag, 0);
    burst(12, 4, 2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule